// File: doc/BRIEF.md
# USB Host Clock and Reset Bring-Up Sequencer

This block releases the clocks and resets of a USB host controller and its PHY in a fixed order after a start request. Several clients share it. Each client pulses a start request when it needs the controller and a stop request when it is finished. The block keeps a use count of these requests. Only a start that arrives while the count is zero and the machine is idle launches the sequence. All other requests only change the count.

The sequence enables the interface and puts the PHY into power-on reset. It then latches the reference-clock select and divider code and programs the host clock divider. The divider value is quantized from the I/O clock frequency, which is a parameter. Next it enables the host divider, releases that divider's reset and clears PHY power-on reset. It then pulses the test-equipment reset. After that it brings up the second clock divider, releases PHY reset and finally releases host reset. Every wait is counted in I/O clock cycles and rounded up from its time value.

At the end the block applies fixed per-port tuning values and a frame-length adjust value, then raises a done flag. If host reset is already released when a new sequence starts, the whole bring-up is skipped and only the tuning step is repeated.

Top module: `usbclk_seq`

## Requirements
- R1: After reset the outputs are as follows. Power-on reset `phy_por_o` is 1. The active-low signals `phy_rst_no`, `host_rst_no`, `hdiv_rst_no` and `odiv_rst_no` are 0. The enables `if_en_o`, `hdiv_en_o` and `odiv_en_o` are 0. `ate_rst_o` is 0, `done_o` is 0, `use_cnt_o` is 0, and the tuning outputs are 0.
- R2: A start with no stop in the same cycle raises `use_cnt_o` by one, saturating at 2^CNT_W-1. A stop with no start lowers it by one, and a stop at zero leaves it at zero. A start and a stop in the same cycle leave it unchanged. A stop never aborts a running sequence.
- R3: The sequence launches only on a start seen while the count is zero and the machine is idle. Extra starts during a run neither restart nor alter the run.
- R4: One cycle after launch `if_en_o` is 1. One cycle later `phy_por_o` is 1, and `phy_rst_no`, `host_rst_no`, both divider resets and both divider enables are 0.
- R5: `ref_sel_o` is latched as 0 for a crystal (`ref_crystal_i`=1) and 1 for an external clock. `ref_div_o` is latched as 0 for 12 MHz, 1 for 24 MHz and 2 for 48 MHz; any other `ref_hz_i` gives 0.
- R6: `host_div_o` is derived from q = IO_CLK_HZ / 130 MHz (integer division). q=0 gives 1 and q of 1 to 4 gives q. q=5 gives 4, q of 6 or 7 gives 6, q of 8 to 11 gives 8, and q of 12 or more gives 12.
- R7: `hdiv_en_o` rises, and `hdiv_rst_no` rises exactly one cycle later. `phy_por_o` falls exactly 64 cycles after that.
- R8: `ate_rst_o` rises exactly ceil(1 ms x IO_CLK_HZ) cycles after `phy_por_o` falls. It stays high for exactly ceil(10 ns x IO_CLK_HZ) cycles. `odiv_rst_no` rises exactly ceil(20 ns x IO_CLK_HZ) cycles after it falls.
- R9: `odiv_en_o` rises one cycle after `odiv_rst_no`. `phy_rst_no` rises exactly 64 cycles after `odiv_en_o`. `host_rst_no` rises exactly ceil(1 us x IO_CLK_HZ) cycles after `phy_rst_no`.
- R10: When `done_o` rises, every port shows the following tuning values: voltage-reference 15 (field [4k+3:4k] of `vref_tune_o`), rise 1 (field [2k+1:2k]) and pre-emphasis 1 (field [2k+1:2k]). `fla_o` is 0x20 at the same time. All of these hold afterwards.
- R11: A launch while `host_rst_no` is 1 clears `done_o`. It raises `done_o` again two cycles later without any change to `phy_por_o`, `ate_rst_o` or the reset outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Client start request, one per cycle |
| stop_i | input | 1 | Client stop request, one per cycle |
| ref_crystal_i | input | 1 | 1 when the PHY reference is a crystal |
| ref_hz_i | input | 32 | Reference clock rate in Hz |
| if_en_o | output | 1 | Interface clock enable |
| phy_por_o | output | 1 | PHY power-on reset, active high |
| phy_rst_no | output | 1 | PHY reset, active low |
| host_rst_no | output | 1 | Host controller reset, active low |
| hdiv_en_o | output | 1 | Host clock divider enable |
| hdiv_rst_no | output | 1 | Host clock divider reset, active low |
| odiv_en_o | output | 1 | Second clock divider enable |
| odiv_rst_no | output | 1 | Second clock divider reset, active low |
| ate_rst_o | output | 1 | Test-equipment reset pulse to the PHY |
| ref_sel_o | output | 1 | Reference select, 0 crystal, 1 external |
| ref_div_o | output | 2 | Reference divider code |
| host_div_o | output | 4 | Host clock divider value |
| vref_tune_o | output | N_PORTS*4 | Per-port voltage-reference tuning |
| rise_tune_o | output | N_PORTS*2 | Per-port rise-time tuning |
| preemph_tune_o | output | N_PORTS*2 | Per-port pre-emphasis tuning |
| fla_o | output | 6 | Frame-length adjust value |
| use_cnt_o | output | CNT_W | Current use count |
| done_o | output | 1 | Bring-up and tuning complete |

## Verification
The full bring-up is run once at a 150 MHz I/O clock with an external 48 MHz reference. The distance between every pair of consecutive output edges is measured, which separates a wrong step order from a wrong rounding of a time wait. During the one-millisecond wait, random start/stop mixes drive the use count, including stops at zero and saturation, to show that the count never disturbs the running sequence. Six further instances built for I/O clocks on each side of the divider table's breakpoints, with assorted reference types and rates, cover every quantization band and every reference code. A final relaunch after host reset is already released tells the skip path apart from a full rerun.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_IFEN, ST_POR, ST_REF, ST_HDIV, ST_HEN, ST_HREL, ST_PORCLR,
    ST_ATE_ON, ST_ATE_OFF, ST_OREL, ST_OEN, ST_PREL, ST_HOSTREL, ST_TUNE, ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic if_en;
    logic phy_por;
    logic phy_rst_n;
    logic host_rst_n;
    logic hdiv_en;
    logic odiv_en;
    logic hdiv_rst_n;
    logic odiv_rst_n;
    logic ate_rst;
  } rst_ctrl_t;

  localparam rst_ctrl_t CTRL_RESET = '{
    if_en: 1'b0, phy_por: 1'b1, phy_rst_n: 1'b0, host_rst_n: 1'b0,
    hdiv_en: 1'b0, odiv_en: 1'b0, hdiv_rst_n: 1'b0, odiv_rst_n: 1'b0,
    ate_rst: 1'b0
  };

  // wait length in clock cycles, rounded up, never below one
  function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                   longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic logic [3:0] host_div_map(longint unsigned io_hz);
    longint unsigned q;
    q = io_hz / 64'd130_000_000;
    if (q == 0)       return 4'd1;
    else if (q <= 4)  return 4'(q);
    else if (q == 5)  return 4'd4;
    else if (q <= 7)  return 4'd6;
    else if (q <= 11) return 4'd8;
    else              return 4'd12;
  endfunction

  function automatic logic [1:0] ref_div_code(logic [31:0] hz);
    case (hz)
      32'd24_000_000: return 2'd1;
      32'd48_000_000: return 2'd2;
      default:        return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/usbclk_use_cnt.sv
module usbclk_use_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             first_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic inc, dec;

  assign inc     = start_i && !stop_i && (cnt_q != CNT_MAX);
  assign dec     = stop_i && !start_i && (cnt_q != '0);
  assign first_o = start_i && !stop_i && (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
    else if (dec) cnt_q <= cnt_q - 1'b1;
  end

  a_r2_stop_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i && cnt_q == '0) |=> (cnt_q == '0));
  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  a_r2_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && stop_i) |=> $stable(cnt_q));

endmodule

// File: rtl/usbclk_step_timer.sv
module usbclk_step_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  a_r8_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);

endmodule

// File: rtl/usbclk_div_sel.sv
module usbclk_div_sel
  import usbclk_pkg::*;
#(
  parameter longint unsigned IO_CLK_HZ = 64'd150_000_000
) (
  input  logic        ref_crystal_i,
  input  logic [31:0] ref_hz_i,
  output logic        ref_sel_o,
  output logic [1:0]  ref_div_o,
  output logic [3:0]  host_div_o
);
  localparam logic [3:0] HOST_DIV = host_div_map(IO_CLK_HZ);

  assign ref_sel_o  = !ref_crystal_i;
  assign ref_div_o  = ref_div_code(ref_hz_i);
  assign host_div_o = HOST_DIV;

endmodule

// File: rtl/usbclk_seq.sv
module usbclk_seq
  import usbclk_pkg::*;
#(
  parameter longint unsigned IO_CLK_HZ = 64'd150_000_000,
  parameter int unsigned N_PORTS   = 2,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned VREF_W    = 4,
  parameter int unsigned RISE_W    = 2,
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned FLA_W     = 6,
  parameter int unsigned VREF_VAL  = 15,
  parameter int unsigned RISE_VAL  = 1,
  parameter int unsigned PRE_VAL   = 1,
  parameter int unsigned FLA_VAL   = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic                      ref_crystal_i,
  input  logic [31:0]               ref_hz_i,
  output logic                      if_en_o,
  output logic                      phy_por_o,
  output logic                      phy_rst_no,
  output logic                      host_rst_no,
  output logic                      hdiv_en_o,
  output logic                      hdiv_rst_no,
  output logic                      odiv_en_o,
  output logic                      odiv_rst_no,
  output logic                      ate_rst_o,
  output logic                      ref_sel_o,
  output logic [1:0]                ref_div_o,
  output logic [3:0]                host_div_o,
  output logic [N_PORTS*VREF_W-1:0] vref_tune_o,
  output logic [N_PORTS*RISE_W-1:0] rise_tune_o,
  output logic [N_PORTS*PRE_W-1:0]  preemph_tune_o,
  output logic [FLA_W-1:0]          fla_o,
  output logic [CNT_W-1:0]          use_cnt_o,
  output logic                      done_o
);
  localparam longint unsigned CYC_10NS  = ns_to_cycles(64'd10, IO_CLK_HZ);
  localparam longint unsigned CYC_20NS  = ns_to_cycles(64'd20, IO_CLK_HZ);
  localparam longint unsigned CYC_1US   = ns_to_cycles(64'd1_000, IO_CLK_HZ);
  localparam longint unsigned CYC_1MS   = ns_to_cycles(64'd1_000_000, IO_CLK_HZ);
  localparam longint unsigned CYC_DIV   = 64;
  localparam longint unsigned MAX_DWELL = (CYC_1MS > CYC_DIV) ? CYC_1MS : CYC_DIV;
  localparam int unsigned     TMR_W     = $clog2(MAX_DWELL + 1);

  seq_st_e          st_q, st_nxt;
  rst_ctrl_t        ctrl_q;
  logic             done_q, tuned_q;
  logic             ref_sel_q;
  logic [1:0]       ref_div_q;
  logic [3:0]       host_div_q;
  logic             first, fire, adv, expire;
  logic [TMR_W-1:0] dwell;
  logic             sel_ref_sel;
  logic [1:0]       sel_ref_div;
  logic [3:0]       sel_host_div;

  usbclk_use_cnt #(.CNT_W(CNT_W)) u_use_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .first_o (first),
    .cnt_o   (use_cnt_o)
  );

  usbclk_div_sel #(.IO_CLK_HZ(IO_CLK_HZ)) u_div_sel (
    .ref_crystal_i (ref_crystal_i),
    .ref_hz_i      (ref_hz_i),
    .ref_sel_o     (sel_ref_sel),
    .ref_div_o     (sel_ref_div),
    .host_div_o    (sel_host_div)
  );

  always_comb begin
    unique case (st_q)
      ST_HREL, ST_OEN: dwell = TMR_W'(CYC_DIV);
      ST_PORCLR:       dwell = TMR_W'(CYC_1MS);
      ST_ATE_ON:       dwell = TMR_W'(CYC_10NS);
      ST_ATE_OFF:      dwell = TMR_W'(CYC_20NS);
      ST_PREL:         dwell = TMR_W'(CYC_1US);
      default:         dwell = TMR_W'(1);
    endcase
  end

  assign fire = first && (st_q == ST_IDLE);
  assign adv  = (st_q != ST_IDLE) && expire;

  usbclk_step_timer #(.W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (adv || (st_q == ST_IDLE)),
    .limit_i   (dwell),
    .expire_o  (expire)
  );

  always_comb begin
    unique case (st_q)
      ST_IFEN:    st_nxt = ctrl_q.host_rst_n ? ST_TUNE : ST_POR;
      ST_POR:     st_nxt = ST_REF;
      ST_REF:     st_nxt = ST_HDIV;
      ST_HDIV:    st_nxt = ST_HEN;
      ST_HEN:     st_nxt = ST_HREL;
      ST_HREL:    st_nxt = ST_PORCLR;
      ST_PORCLR:  st_nxt = ST_ATE_ON;
      ST_ATE_ON:  st_nxt = ST_ATE_OFF;
      ST_ATE_OFF: st_nxt = ST_OREL;
      ST_OREL:    st_nxt = ST_OEN;
      ST_OEN:     st_nxt = ST_PREL;
      ST_PREL:    st_nxt = ST_HOSTREL;
      ST_HOSTREL: st_nxt = ST_TUNE;
      ST_TUNE:    st_nxt = ST_FIN;
      default:    st_nxt = ST_IDLE;
    endcase
  end

  // actions happen on entry to a step; the dwell is counted inside it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ctrl_q     <= CTRL_RESET;
      done_q     <= 1'b0;
      tuned_q    <= 1'b0;
      ref_sel_q  <= 1'b0;
      ref_div_q  <= '0;
      host_div_q <= '0;
    end else if (fire) begin
      st_q         <= ST_IFEN;
      ctrl_q.if_en <= 1'b1;
      done_q       <= 1'b0;
    end else if (adv) begin
      st_q <= st_nxt;
      unique case (st_nxt)
        ST_POR: begin
          ctrl_q.phy_por    <= 1'b1;
          ctrl_q.phy_rst_n  <= 1'b0;
          ctrl_q.host_rst_n <= 1'b0;
          ctrl_q.hdiv_rst_n <= 1'b0;
          ctrl_q.odiv_rst_n <= 1'b0;
          ctrl_q.hdiv_en    <= 1'b0;
          ctrl_q.odiv_en    <= 1'b0;
        end
        ST_REF: begin
          ref_sel_q <= sel_ref_sel;
          ref_div_q <= sel_ref_div;
        end
        ST_HDIV:    host_div_q        <= sel_host_div;
        ST_HEN:     ctrl_q.hdiv_en    <= 1'b1;
        ST_HREL:    ctrl_q.hdiv_rst_n <= 1'b1;
        ST_PORCLR:  ctrl_q.phy_por    <= 1'b0;
        ST_ATE_ON:  ctrl_q.ate_rst    <= 1'b1;
        ST_ATE_OFF: ctrl_q.ate_rst    <= 1'b0;
        ST_OREL:    ctrl_q.odiv_rst_n <= 1'b1;
        ST_OEN:     ctrl_q.odiv_en    <= 1'b1;
        ST_PREL:    ctrl_q.phy_rst_n  <= 1'b1;
        ST_HOSTREL: ctrl_q.host_rst_n <= 1'b1;
        ST_TUNE:    tuned_q           <= 1'b1;
        ST_FIN:     done_q            <= 1'b1;
        default: ;
      endcase
    end
  end

  assign if_en_o     = ctrl_q.if_en;
  assign phy_por_o   = ctrl_q.phy_por;
  assign phy_rst_no  = ctrl_q.phy_rst_n;
  assign host_rst_no = ctrl_q.host_rst_n;
  assign hdiv_en_o   = ctrl_q.hdiv_en;
  assign hdiv_rst_no = ctrl_q.hdiv_rst_n;
  assign odiv_en_o   = ctrl_q.odiv_en;
  assign odiv_rst_no = ctrl_q.odiv_rst_n;
  assign ate_rst_o   = ctrl_q.ate_rst;
  assign ref_sel_o   = ref_sel_q;
  assign ref_div_o   = ref_div_q;
  assign host_div_o  = host_div_q;
  assign done_o      = done_q;
  assign fla_o       = tuned_q ? FLA_W'(FLA_VAL) : '0;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    assign vref_tune_o[g*VREF_W +: VREF_W]  = tuned_q ? VREF_W'(VREF_VAL) : '0;
    assign rise_tune_o[g*RISE_W +: RISE_W]  = tuned_q ? RISE_W'(RISE_VAL) : '0;
    assign preemph_tune_o[g*PRE_W +: PRE_W] = tuned_q ? PRE_W'(PRE_VAL) : '0;
  end

  a_r7_por_after_hdiv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_por_o) |-> (hdiv_en_o && hdiv_rst_no));
  a_r8_ate_after_por: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ate_rst_o |-> !phy_por_o);
  a_r9_host_after_phy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_rst_no) |-> (phy_rst_no && odiv_en_o && odiv_rst_no));
  a_r9_phy_after_odiv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_rst_no) |-> odiv_en_o);
  a_r10_done_tuned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fla_o == FLA_W'(FLA_VAL)));
  a_r11_no_por_rerise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(phy_por_o));

endmodule

// File: tb/usbclk_seq_test.sv
module usbclk_seq_test;
  localparam longint unsigned MAIN_HZ = 64'd150_000_000;
  localparam int NX = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, stop = 1'b0, xstart = 1'b0;
  always #5 clk = ~clk;

  logic if_en, por, phy_rn, host_rn, hen, hrn, oen, orn, ate, rsel, done;
  logic [1:0] rdiv;
  logic [3:0] hdiv, cnt;
  logic [7:0] vref;
  logic [3:0] rise, pre;
  logic [5:0] fla;

  usbclk_seq #(.IO_CLK_HZ(MAIN_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .stop_i(stop),
    .ref_crystal_i(1'b0), .ref_hz_i(32'd48_000_000),
    .if_en_o(if_en), .phy_por_o(por), .phy_rst_no(phy_rn), .host_rst_no(host_rn),
    .hdiv_en_o(hen), .hdiv_rst_no(hrn), .odiv_en_o(oen), .odiv_rst_no(orn),
    .ate_rst_o(ate), .ref_sel_o(rsel), .ref_div_o(rdiv), .host_div_o(hdiv),
    .vref_tune_o(vref), .rise_tune_o(rise), .preemph_tune_o(pre), .fla_o(fla),
    .use_cnt_o(cnt), .done_o(done));

  function automatic longint unsigned x_hz(int k);
    case (k)
      0: return 64'd650_000_000;
      1: return 64'd800_000_000;
      2: return 64'd1_500_000_000;
      3: return 64'd2_000_000_000;
      4: return 64'd100_000_000;
      default: return 64'd520_000_000;
    endcase
  endfunction
  function automatic logic x_crys(int k);
    return (k == 0 || k == 2 || k == 4);
  endfunction
  function automatic logic [31:0] x_rhz(int k);
    case (k)
      0, 5: return 32'd24_000_000;
      1, 4: return 32'd12_000_000;
      2:    return 32'd30_000_000;
      default: return 32'd48_000_000;
    endcase
  endfunction

  // expected values straight from the requirement tables
  function automatic longint exp_hdiv(longint unsigned hz);
    if (hz < 64'd130_000_000)       return 1;
    else if (hz < 64'd650_000_000)  return hz / 64'd130_000_000;
    else if (hz < 64'd780_000_000)  return 4;
    else if (hz < 64'd1_040_000_000) return 6;
    else if (hz < 64'd1_560_000_000) return 8;
    else                             return 12;
  endfunction
  function automatic longint exp_rdiv(logic [31:0] hz);
    if (hz == 32'd24_000_000) return 1;
    if (hz == 32'd48_000_000) return 2;
    return 0;
  endfunction

  logic       x_sel [NX];
  logic [1:0] x_div [NX];
  logic [3:0] x_hd  [NX];
  logic x_ie[NX], x_po[NX], x_pr[NX], x_hr[NX], x_he[NX], x_hn[NX];
  logic x_oe[NX], x_on[NX], x_at[NX], x_dn[NX];
  logic [7:0] x_vr[NX];
  logic [3:0] x_ri[NX], x_pe[NX], x_cn[NX];
  logic [5:0] x_fl[NX];

  for (genvar k = 0; k < NX; k++) begin : g_x
    usbclk_seq #(.IO_CLK_HZ(x_hz(k))) u_x (
      .clk_i(clk), .rst_ni(rst_ni), .start_i(xstart), .stop_i(1'b0),
      .ref_crystal_i(x_crys(k)), .ref_hz_i(x_rhz(k)),
      .if_en_o(x_ie[k]), .phy_por_o(x_po[k]), .phy_rst_no(x_pr[k]),
      .host_rst_no(x_hr[k]), .hdiv_en_o(x_he[k]), .hdiv_rst_no(x_hn[k]),
      .odiv_en_o(x_oe[k]), .odiv_rst_no(x_on[k]), .ate_rst_o(x_at[k]),
      .ref_sel_o(x_sel[k]), .ref_div_o(x_div[k]), .host_div_o(x_hd[k]),
      .vref_tune_o(x_vr[k]), .rise_tune_o(x_ri[k]), .preemph_tune_o(x_pe[k]),
      .fla_o(x_fl[k]), .use_cnt_o(x_cn[k]), .done_o(x_dn[k]));
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  int model = 0;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one request cycle on the main instance, model updated per R2
  task automatic req(bit s, bit p);
    start = s; stop = p;
    @(posedge clk); #1;
    start = 1'b0; stop = 1'b0;
    if (s && !p && model < 15) model++;
    else if (p && !s && model > 0) model--;
  endtask

  // edge timing monitor
  longint cyc = 0;
  longint t_hen = -1, t_hrel = -1, t_porclr = -1, t_ater = -1, t_atef = -1;
  longint t_orel = -1, t_oen = -1, t_prel = -1, t_hostrel = -1;
  int ate_rises = 0;
  logic p_hen = 0, p_hrn = 0, p_por = 1, p_ate = 0, p_orn = 0, p_oen = 0;
  logic p_phy = 0, p_host = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (!p_hen && hen && t_hen < 0) t_hen = cyc;
      if (!p_hrn && hrn && t_hrel < 0) t_hrel = cyc;
      if (p_por && !por && t_porclr < 0) t_porclr = cyc;
      if (!p_ate && ate) begin ate_rises++; if (t_ater < 0) t_ater = cyc; end
      if (p_ate && !ate && t_atef < 0) t_atef = cyc;
      if (!p_orn && orn && t_orel < 0) t_orel = cyc;
      if (!p_oen && oen && t_oen < 0) t_oen = cyc;
      if (!p_phy && phy_rn && t_prel < 0) t_prel = cyc;
      if (!p_host && host_rn && t_hostrel < 0) t_hostrel = cyc;
    end
    p_hen = hen; p_hrn = hrn; p_por = por; p_ate = ate; p_orn = orn;
    p_oen = oen; p_phy = phy_rn; p_host = host_rn;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 por", por, 1); chk("R1 phy_rst_n", phy_rn, 0);
    chk("R1 host_rst_n", host_rn, 0); chk("R1 hdiv_rst_n", hrn, 0);
    chk("R1 odiv_rst_n", orn, 0); chk("R1 enables", {if_en, hen, oen}, 0);
    chk("R1 ate/done", {ate, done}, 0); chk("R1 count", cnt, 0);
    chk("R1 tuning", {vref, rise, pre, fla}, 0);

    // R2 stop at zero ignored, no launch
    req(0, 1); @(negedge clk);
    chk("R2 stop at zero", cnt, 0);
    chk("R3 no launch on stop", if_en, 0);

    // launch all instances together
    @(posedge clk); #1;
    start = 1'b1; xstart = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; xstart = 1'b0; model = 1;
    @(negedge clk);
    chk("R4 if_en after launch", if_en, 1);
    chk("R2 first start count", cnt, 1);
    @(negedge clk);
    chk("R4 por held", por, 1);
    chk("R4 resets held", {phy_rn, host_rn, hrn, orn}, 0);
    chk("R4 enables low", {hen, oen}, 0);
    // R3 extra start mid-run only counts
    req(1, 0); @(negedge clk);
    chk("R3 extra start count", cnt, 2);
    repeat (4) @(negedge clk);
    chk("R5 main ref_sel external", rsel, 1);
    chk("R5 main ref_div 48MHz", rdiv, 2);
    chk("R6 main host_div", hdiv, exp_hdiv(MAIN_HZ));
    for (int k = 0; k < NX; k++) begin
      chk("R5 ref_sel", x_sel[k], x_crys(k) ? 0 : 1);
      chk("R5 ref_div", x_div[k], exp_rdiv(x_rhz(k)));
      chk("R6 host_div", x_hd[k], exp_hdiv(x_hz(k)));
    end

    // R2 random request mix while the long wait runs
    for (int i = 0; i < 3000; i++) begin
      bit s, p;
      s = ($urandom % 3) != 0;
      p = ($urandom % 3) == 0;
      req(s, p); @(negedge clk);
      chk("R2 random count", cnt, model);
    end
    for (int i = 0; i < 20; i++) begin
      req(1, 0); @(negedge clk);
    end
    chk("R2 saturate", cnt, 15);
    req(1, 1); @(negedge clk);
    chk("R2 start+stop hold", cnt, 15);

    for (int i = 0; i < 170000 && !done; i++) @(negedge clk);
    chk("R10 done reached", done, 1);
    chk("R7 hdiv rst after en", t_hrel - t_hen, 1);
    chk("R7 por clear after 64", t_porclr - t_hrel, 64);
    chk("R8 1ms wait", t_ater - t_porclr, 150000);
    chk("R8 ate width", t_atef - t_ater, 2);
    chk("R8 20ns wait", t_orel - t_atef, 3);
    chk("R9 odiv en after rst", t_oen - t_orel, 1);
    chk("R9 phy after 64", t_prel - t_oen, 64);
    chk("R9 host after 1us", t_hostrel - t_prel, 150);
    for (int k = 0; k < 2; k++) begin
      chk("R10 vref", vref[4*k +: 4], 15);
      chk("R10 rise", rise[2*k +: 2], 1);
      chk("R10 preemph", pre[2*k +: 2], 1);
    end
    chk("R10 fla", fla, 32);
    chk("R3 single ate pulse", ate_rises, 1);

    // R11 relaunch with host reset released
    while (model > 0) begin
      req(0, 1); @(negedge clk);
      chk("R2 drain", cnt, model);
    end
    req(1, 0);
    @(negedge clk);
    chk("R11 done cleared", done, 0);
    @(negedge clk);
    chk("R11 done still low", done, 0);
    @(negedge clk);
    chk("R11 done back", done, 1);
    chk("R11 por untouched", por, 0);
    chk("R11 resets untouched", {phy_rn, host_rn, hrn, orn}, 4'hf);
    chk("R11 no ate pulse", ate_rises, 1);
    chk("R10 tuning kept", fla, 32);
    finish_run();
  end
endmodule